// File: doc/BRIEF.md
# Core Clock Source Selector and Power-of-Two Divider

This block chooses which clock feeds the processor core and turns that clock into a core clock enable. The available sources are a PLL locked to the internal 32.768 kHz reference, the same PLL locked to an external 32.768 kHz crystal, and an external clock pin. The core runs at the selected clock divided by a power of two, set by a 3-bit divide code. Outside this block, an enable pulse gates the core, so one `core_en` pulse is one core clock.

Software writes a requested source and a divide code through a single write strobe. A new divide code is picked up only when the current divided period ends. A new source is never applied while the core runs. Instead it is held as pending, and it is committed only when the part leaves sleep (NAP) on a wake-up event and the requested source reports a valid clock. The oscillators and the PLL are outside the block. Each source appears only as a clock-valid bit.

The controller is a three-state machine:
- **RUN**: the divider counts.
- **NAP**: the core is asleep.
- **COMMIT**: a single cycle in which the new source takes over.

The transitions are:
- RUN→NAP on a sleep request.
- NAP→COMMIT on a wake event when a switch is pending and its target is valid.
- NAP→RUN on a wake event otherwise.
- COMMIT→RUN unconditionally.

Top module: `clk_core_ctl`

## Requirements
- R1: After reset the active source is 00 (internal-reference PLL), no switch is pending, `asleep` is 0, and the divide code is 3, so `core_en` is high in the 8th cycle after reset release and every 8th cycle after that.
- R2: With an active divide code D (0 to 7), `core_en` is a single-cycle pulse once every 2^D clocks while in RUN. With D = 0 it is high on every clock.
- R3: A written divide code takes effect only at the end of the period in progress. That period completes at its old length, and the next period has the new length.
- R4: Source codes are 00 internal-reference PLL, 01 external-crystal PLL, 10 external clock pin, and 11 reserved. A write carrying source code 11 leaves the requested source unchanged, while its divide field is still taken.
- R5: A write whose source code differs from the active source raises `src_pending` in the next cycle. `active_src` never changes while in RUN.
- R6: `nap_req` sampled in RUN moves the block to NAP in the next cycle. `asleep` is 1 and `core_en` is 0 throughout NAP and COMMIT.
- R7: In NAP, a `wake_evt` with a switch pending and the valid bit of the requested source set (`src_ok` bit index = source code) leads to COMMIT for exactly one cycle and then RUN. `active_src` takes the requested value and `src_pending` clears as COMMIT is entered.
- R8: In NAP, a `wake_evt` with no switch pending, or with the requested source's valid bit clear, returns directly to RUN. The source is unchanged and any pending request is kept.
- R9: On return to RUN the divider restarts from zero with the most recently written code D. The first `core_en` comes in the 2^D-th cycle in RUN.
- R10: `wake_evt` while in RUN and `nap_req` while in NAP have no effect on state, source or enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Undivided selected clock driving the controller |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration fields |
| cfg_src | input | 2 | Requested source code (R4 encoding) |
| cfg_div | input | 3 | Requested divide code D, ratio 2^D |
| nap_req | input | 1 | Sleep request, sampled in RUN |
| wake_evt | input | 1 | Wake-up event, sampled in NAP |
| src_ok | input | 3 | Clock-valid bit per source, indexed by source code |
| core_en | output | 1 | Core clock enable, one pulse per divided period |
| active_src | output | 2 | Currently committed source code |
| src_pending | output | 1 | A requested source differs from the active one |
| asleep | output | 1 | High in NAP and COMMIT |

## Verification
The bench targets the deferred divide reload by writing a new code in the middle of a long period. A design that reloaded at once would produce a shortened pulse gap, which the per-cycle model comparison catches. It also wakes the part twice: once with the crystal reported invalid and once with it valid. A design that committed without checking validity would change `active_src` too early, and one that dropped the request would lose `src_pending`. Reserved source writes, wake events while running and sleep requests while asleep are all applied. A design that honoured them would show a wrong source, pending flag or enable on the ports. After every wake the bench checks that the restarted divider gives a full first period at the newly written ratio.

// File: rtl/clk_ctl_pkg.sv
`timescale 1ns/1ps
package clk_ctl_pkg;

    localparam int SRC_W = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_INT_PLL  = 2'b00,
        SRC_XTAL_PLL = 2'b01,
        SRC_EXT_PIN  = 2'b10,
        SRC_RSVD     = 2'b11
    } clk_src_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'b00,
        ST_NAP    = 2'b01,
        ST_COMMIT = 2'b10
    } pwr_state_e;

endpackage

// File: rtl/clk_cfg_reg.sv
`timescale 1ns/1ps
module clk_cfg_reg
    import clk_ctl_pkg::*;
#(
    parameter int DIV_W   = 3,
    parameter int RST_DIV = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SRC_W-1:0] src_in,
    input  logic [DIV_W-1:0] div_in,
    output logic [SRC_W-1:0] req_src,
    output logic [DIV_W-1:0] req_div
);

    logic src_take;

    // reserved source code is dropped; divide field is always taken
    always_comb begin
        src_take = we && (src_in != SRC_RSVD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_src <= SRC_INT_PLL;
        end else if (src_take) begin
            req_src <= src_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_div <= DIV_W'(RST_DIV);
        end else if (we) begin
            req_div <= div_in;
        end
    end

endmodule

// File: rtl/clk_src_fsm.sv
`timescale 1ns/1ps
module clk_src_fsm
    import clk_ctl_pkg::*;
#(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nap_req,
    input  logic               wake_evt,
    input  logic [NUM_SRC-1:0] src_ok,
    input  logic [SRC_W-1:0]   req_src,
    output pwr_state_e         state_q,
    output logic [SRC_W-1:0]   act_src,
    output logic               pending,
    output logic               running,
    output logic               sleeping
);

    pwr_state_e         state_d;
    logic [NUM_SRC-1:0] ok_hit;
    logic               target_ok;
    logic               do_commit;

    // valid bit of the requested source
    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_ok
            assign ok_hit[g] = src_ok[g] && (req_src == SRC_W'(g));
        end
    endgenerate

    assign target_ok = |ok_hit;
    assign pending   = (req_src != act_src);
    assign do_commit = (state_q == ST_NAP) && wake_evt && pending && target_ok;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (nap_req) state_d = ST_NAP;
            end
            ST_NAP: begin
                if (wake_evt) state_d = do_commit ? ST_COMMIT : ST_RUN;
            end
            ST_COMMIT: begin
                state_d = ST_RUN;
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // committed source register, loaded on NAP -> COMMIT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_src <= SRC_INT_PLL;
        end else if (do_commit) begin
            act_src <= req_src;
        end
    end

    // outputs
    always_comb begin
        running  = 1'b0;
        sleeping = 1'b1;
        unique case (state_q)
            ST_RUN:    begin running = 1'b1; sleeping = 1'b0; end
            ST_NAP:    begin running = 1'b0; sleeping = 1'b1; end
            ST_COMMIT: begin running = 1'b0; sleeping = 1'b1; end
            default:   begin running = 1'b0; sleeping = 1'b1; end
        endcase
    end

endmodule

// File: rtl/clk_div_gen.sv
`timescale 1ns/1ps
module clk_div_gen #(
    parameter int DIV_W   = 3,
    parameter int RST_DIV = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] req_div,
    output logic             core_en,
    output logic [DIV_W-1:0] div_active
);

    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             wrap;

    // terminal count 2^D - 1 as a thermometer mask
    generate
        for (genvar b = 0; b < CNT_W; b++) begin : g_lim
            assign limit[b] = (32'(div_active) > b);
        end
    endgenerate

    assign wrap    = (cnt_q == limit);
    assign core_en = run && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            div_active <= DIV_W'(RST_DIV);
        end else if (!run) begin
            cnt_q      <= '0;
            div_active <= req_div;
        end else if (wrap) begin
            cnt_q      <= '0;
            div_active <= req_div;
        end else begin
            cnt_q      <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/clk_core_ctl.sv
`timescale 1ns/1ps
module clk_core_ctl
    import clk_ctl_pkg::*;
#(
    parameter int DIV_W   = 3,
    parameter int RST_DIV = 3,
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_src,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic               nap_req,
    input  logic               wake_evt,
    input  logic [NUM_SRC-1:0] src_ok,
    output logic               core_en,
    output logic [1:0]         active_src,
    output logic               src_pending,
    output logic               asleep
);

    logic [SRC_W-1:0] req_src;
    logic [DIV_W-1:0] req_div;
    logic [DIV_W-1:0] div_active;
    logic             running;
    pwr_state_e       state_q;

    clk_cfg_reg #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .src_in  (cfg_src),
        .div_in  (cfg_div),
        .req_src (req_src),
        .req_div (req_div)
    );

    clk_src_fsm #(.NUM_SRC(NUM_SRC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .nap_req  (nap_req),
        .wake_evt (wake_evt),
        .src_ok   (src_ok),
        .req_src  (req_src),
        .state_q  (state_q),
        .act_src  (active_src),
        .pending  (src_pending),
        .running  (running),
        .sleeping (asleep)
    );

    clk_div_gen #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (running),
        .req_div    (req_div),
        .core_en    (core_en),
        .div_active (div_active)
    );

endmodule

// File: rtl/clk_core_ctl_chk.sv
`timescale 1ns/1ps
module clk_core_ctl_chk
    import clk_ctl_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [1:0] cfg_src,
    input logic       wake_evt,
    input logic       core_en,
    input logic [1:0] active_src,
    input logic       src_pending,
    input logic       asleep,
    input pwr_state_e state_q
);

    // R6
    en_while_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> !core_en);

    // R5
    src_stable_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !asleep |=> (active_src == $past(active_src)));

    // R7
    commit_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> (state_q == ST_RUN));

    // R7
    commit_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |-> !src_pending);

    // R10
    nap_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_NAP) && !wake_evt) |=> (state_q == ST_NAP));

    // R4
    rsvd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_src == 2'b11) && (state_q == ST_RUN)) |=> $stable(src_pending));

endmodule

bind clk_core_ctl clk_core_ctl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_src     (cfg_src),
    .wake_evt    (wake_evt),
    .core_en     (core_en),
    .active_src  (active_src),
    .src_pending (src_pending),
    .asleep      (asleep),
    .state_q     (state_q)
);

// File: tb/clk_core_ctl_tb.sv
`timescale 1ns/1ps
module clk_core_ctl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_src = 2'b00;
    logic [2:0] cfg_div = 3'd0;
    logic       nap_req = 1'b0;
    logic       wake_evt = 1'b0;
    logic [2:0] src_ok = 3'b111;
    logic       core_en;
    logic [1:0] active_src;
    logic       src_pending;
    logic       asleep;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    string tag = "R1";

    // reference model state: 0 run, 1 nap, 2 commit
    int m_state, m_act, m_req, m_reqdiv, m_actdiv, m_cnt;

    always #2.5 clk = ~clk;

    clk_core_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src),
        .cfg_div(cfg_div), .nap_req(nap_req), .wake_evt(wake_evt),
        .src_ok(src_ok), .core_en(core_en), .active_src(active_src),
        .src_pending(src_pending), .asleep(asleep)
    );

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", t, act, exp, cyc);
        end
    endtask

    function automatic int exp_en();
        return (m_state == 0 && m_cnt == (1 << m_actdiv) - 1) ? 1 : 0;
    endfunction

    // behavioural model, updated on every edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_act = 0; m_req = 0; m_reqdiv = 3; m_actdiv = 3; m_cnt = 0;
        end else begin
            int n_req, n_div;
            n_req = (cfg_we && cfg_src != 2'b11) ? int'(cfg_src) : m_req;
            n_div = cfg_we ? int'(cfg_div) : m_reqdiv;
            if (m_state == 0) begin
                if (m_cnt == (1 << m_actdiv) - 1) begin
                    m_cnt = 0; m_actdiv = m_reqdiv;
                end else m_cnt++;
                if (nap_req) m_state = 1;
            end else begin
                m_cnt = 0; m_actdiv = m_reqdiv;
                if (m_state == 2) m_state = 0;
                else if (wake_evt) begin
                    if (m_req != m_act && src_ok[m_req]) begin
                        m_act = m_req; m_state = 2;
                    end else m_state = 0;
                end
            end
            m_req = n_req; m_reqdiv = n_div;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(core_en == exp_en(), {tag, " core_en"}, core_en, exp_en());
            chk(active_src == m_act, "R5 active_src", active_src, m_act);
            chk(src_pending == (m_req != m_act), "R5 src_pending", src_pending, int'(m_req != m_act));
            chk(asleep == (m_state != 0), "R6 asleep", asleep, int'(m_state != 0));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] s, input logic [2:0] d);
        cfg_we = 1'b1; cfg_src = s; cfg_div = d;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic count_en(input int n, output int pulses);
        pulses = 0;
        repeat (n) begin
            @(negedge clk);
            if (core_en) pulses++;
        end
        #1;
    endtask

    initial begin
        int p;
        step(4);
        rst_n = 1'b1;
        // R1 reset state at the ports
        #0.1;
        chk(active_src == 2'b00, "R1 reset source", active_src, 0);
        chk(!src_pending && !asleep, "R1 reset flags", src_pending, 0);
        count_en(32, p);
        chk(p == 4, "R1 pulses per 32 clocks at code 3", p, 4);

        tag = "R2";
        wr(2'b00, 3'd0);
        step(10);
        count_en(10, p);
        chk(p == 10, "R2 code 0 every clock", p, 10);
        wr(2'b00, 3'd7);
        step(130);
        count_en(256, p);
        chk(p == 2, "R2 code 7 pulses in 256", p, 2);

        tag = "R3";
        wr(2'b00, 3'd5);
        step(140);
        wr(2'b00, 3'd1);
        step(80);
        count_en(20, p);
        chk(p == 10, "R3 new code after rollover", p, 10);

        tag = "R4";
        wr(2'b11, 3'd2);
        step(2);
        chk(!src_pending, "R4 reserved source ignored", src_pending, 0);
        count_en(16, p);
        chk(p == 4, "R4 divide field taken", p, 4);

        tag = "R5";
        wr(2'b01, 3'd2);
        #0.1;
        chk(src_pending && active_src == 2'b00, "R5 pending, source held", active_src, 0);
        step(20);

        tag = "R6";
        nap_req = 1'b1; step(1); nap_req = 1'b0;
        #0.1;
        chk(asleep && !core_en, "R6 asleep after request", asleep, 1);
        tag = "R10";
        nap_req = 1'b1; step(6); nap_req = 1'b0;
        chk(asleep, "R10 nap request while asleep", asleep, 1);

        tag = "R8";
        src_ok = 3'b101;
        wake_evt = 1'b1; step(1); wake_evt = 1'b0;
        #0.1;
        chk(!asleep && active_src == 2'b00 && src_pending, "R8 invalid target kept", active_src, 0);
        step(12);

        tag = "R7";
        src_ok = 3'b111;
        nap_req = 1'b1; step(1); nap_req = 1'b0;
        wr(2'b01, 3'd3);
        step(3);
        wake_evt = 1'b1; step(1); wake_evt = 1'b0;
        #0.1;
        chk(asleep && active_src == 2'b01 && !src_pending, "R7 commit cycle", active_src, 1);
        step(1);
        chk(!asleep, "R7 back to run", asleep, 0);

        tag = "R9";
        count_en(8, p);
        chk(p == 1, "R9 first period after wake", p, 1);

        tag = "R10";
        wake_evt = 1'b1; step(5); wake_evt = 1'b0;
        chk(!asleep && active_src == 2'b01, "R10 wake while running", active_src, 1);

        tag = "R7";
        wr(2'b10, 3'd0);
        nap_req = 1'b1; step(1); nap_req = 1'b0;
        step(2);
        wake_evt = 1'b1; step(1); wake_evt = 1'b0;
        step(1);
        chk(active_src == 2'b10, "R7 external pin commit", active_src, 2);
        tag = "R8";
        nap_req = 1'b1; step(1); nap_req = 1'b0;
        wake_evt = 1'b1; step(1); wake_evt = 1'b0;
        #0.1;
        chk(!asleep && active_src == 2'b10, "R8 wake with nothing pending", active_src, 2);
        tag = "R9";
        step(10);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule